// File: doc/BRIEF.md
# I2C Register-File Slave

This block is an I2C target that sits on a two-wire bus and exposes a 20-byte register space to a bus controller. The block answers at the fixed 7-bit device address 1101000, so its write byte is D0h and its read byte is D1h. A system clock oversamples SCL and SDA. The block finds START and STOP conditions and shifts in the device address. In a write it takes a word address, which loads an internal pointer, and then it stores the data bytes. It acknowledges every byte addressed to it by pulling SDA low.

A read can begin in two ways. In a random read, a word-address write is followed by a repeated START. In a current-address read, the read begins at whatever value the pointer last held. The pointer moves only on acknowledge clocks. While an addressed transfer has the pointer inside the timekeeping range 00h–07h, the block raises a freeze request. Neighbouring timekeeping logic uses this request to hold back copy updates. A power-fail input stops all bus activity, clears the pointer and keeps the block deaf to the bus for as long as it is held.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After a START, the block acknowledges a device byte whose upper seven bits are 1101000, with either value of the R/W bit (bit 0). Any other device byte gets no acknowledge, and the block then ignores the bus until the next START, so the data bytes that follow are neither acknowledged nor stored.
- R2: In a write (R/W=0), the first byte after the device byte loads the pointer. A word address of 14h or higher loads 00h. Each later byte is acknowledged and stored at the pointer, and the pointer then steps by one during that byte's acknowledge clock.
- R3: A random read (a word-address write, then a repeated START, then D1h) returns the byte at the given address first. Each controller ACK moves the pointer to the next byte.
- R4: A controller NACK on a read byte leaves the pointer unchanged and stops the block driving SDA. The block then waits for a STOP or START.
- R5: A read that opens directly with D1h, with no word address, returns the byte at the current pointer.
- R6: The pointer steps from 13h to 00h, for writes and for reads alike. It never holds a value above 13h.
- R7: Locations 10h, 11h and 12h always read as 00h, and writes to them are acknowledged but dropped.
- R8: `freeze` is high while an addressed transfer is open and the pointer is in 00h–07h. It falls on STOP, or when the pointer reaches 08h.
- R9: While `pwr_fail` is high, the transfer in progress is abandoned, the pointer returns to 00h, `freeze` is low, SDA is never pulled and the bus is ignored.
- R10: After reset, SDA is released, `freeze` is low, the pointer is 00h and every register reads 00h.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance; abort and ignore the bus |
| scl_in | input | 1 | Bus clock as seen on the pad |
| sda_in | input | 1 | Bus data as seen on the pad |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| freeze | output | 1 | Request to hold timekeeping copy updates |

## Verification
A wrong pointer shows up on the very next byte read from the bus. This is why every start address is swept with multi-byte reads that cross the wrap and the reserved hole. A current-address read after each NACK then exposes any stray step from the previous transfer. A bad protocol state machine shows up as a missing or misplaced acknowledge on the same byte. An SDA drive that changes while SCL is high would look like a false START or STOP, and the bound checker flags it in the cycle where it happens. A freeze request that falls late or early is visible as soon as the acknowledge clock that should move it has ended.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 20,
  parameter int FRZ_TOP  = 8,
  parameter int RSV_LO   = 16,
  parameter int RSV_HI   = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  output logic freeze
);
  localparam int PW = $clog2(NUM_REGS);
  localparam logic [PW-1:0] LAST_P = PW'(NUM_REGS - 1);
  localparam logic [PW-1:0] RLO_P  = PW'(RSV_LO);
  localparam logic [PW-1:0] RHI_P  = PW'(RSV_HI);
  localparam logic [PW-1:0] FRZ_P  = PW'(FRZ_TOP);
  localparam logic [7:0]    NUM8   = 8'(NUM_REGS);

  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2,
                         S_WADR = 4'd3, S_WACK = 4'd4, S_WDAT = 4'd5,
                         S_DACK = 4'd6, S_RDAT = 4'd7, S_RACK = 4'd8,
                         S_IGN  = 4'd9;

  logic [2:0] scl_q, sda_q;
  logic [3:0] st, bitcnt;
  logic [7:0] sh, tx;
  logic [PW-1:0] ptr;
  logic rw, mack, act;
  logic [7:0] mem [NUM_REGS];

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire rise  = scl_s & ~scl_q[2];
  wire fall  = ~scl_s & scl_q[2];
  wire start_det = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop_det  = scl_s & scl_q[2] & ~sda_q[2] & sda_s;

  wire ptr_rsv = (ptr >= RLO_P) && (ptr <= RHI_P);
  wire [PW-1:0] ptr_inc = (ptr == LAST_P) ? '0 : ptr + 1'b1;
  wire [7:0] rdval = ptr_rsv ? 8'h00 : mem[ptr];
  wire byte_done = fall && (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      sh <= '0;
      tx <= '0;
      ptr <= '0;
      rw <= 1'b0;
      mack <= 1'b0;
      act <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (pwr_fail) begin
      st <= S_IDLE;
      ptr <= '0;
      act <= 1'b0;
      bitcnt <= '0;
    end else if (start_det) begin
      st <= S_ADDR;
      bitcnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
      act <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WADR, S_WDAT: begin
          if (rise) begin
            sh <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                st <= S_AACK;
                rw <= sh[0];
                act <= 1'b1;
              end else begin
                st <= S_IGN;
                act <= 1'b0;
              end
            end else if (st == S_WADR) begin
              ptr <= (sh < NUM8) ? sh[PW-1:0] : '0;
              st <= S_WACK;
            end else begin
              if (!ptr_rsv) mem[ptr] <= sh;
              st <= S_DACK;
            end
          end
        end
        S_AACK: if (fall) begin
          bitcnt <= '0;
          if (rw) begin
            st <= S_RDAT;
            tx <= rdval;
          end else begin
            st <= S_WADR;
          end
        end
        S_WACK: if (fall) begin
          st <= S_WDAT;
          bitcnt <= '0;
        end
        S_DACK: begin
          if (rise) ptr <= ptr_inc;
          if (fall) begin
            st <= S_WDAT;
            bitcnt <= '0;
          end
        end
        S_RDAT: if (fall) begin
          if (bitcnt == 4'd7) st <= S_RACK;
          else begin
            bitcnt <= bitcnt + 1'b1;
            tx <= {tx[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (rise) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr_inc;
          end
          if (fall) begin
            if (mack) begin
              st <= S_RDAT;
              tx <= rdval;
              bitcnt <= '0;
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull = (st == S_AACK) || (st == S_WACK) || (st == S_DACK) ||
                    ((st == S_RDAT) && !tx[7]);
  assign freeze = act && (ptr < FRZ_P);
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
  parameter int NUM_REGS = 20
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail,
  input logic sda_pull,
  input logic freeze,
  input logic scl_s,
  input logic [7:0] ptr,
  input logic ptr_load
);
  localparam logic [7:0] LAST8 = 8'(NUM_REGS - 1);

  // R9
  pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && $past(pwr_fail)) |-> (!sda_pull && !freeze));

  // R11
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_fail)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST8);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ptr_load) && !$past(pwr_fail) && (ptr != $past(ptr))) |->
    (ptr == (($past(ptr) == LAST8) ? 8'd0 : $past(ptr) + 8'd1)));
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .pwr_fail(pwr_fail),
  .sda_pull(sda_pull),
  .freeze(freeze),
  .scl_s(scl_q[1]),
  .ptr(8'(ptr)),
  .ptr_load(st == S_WADR)
);

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
  localparam int QC = 10;
  localparam int NR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, freeze;
  wire sda_bus = sda_m & ~sda_pull;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] model [NR];
  int mptr = 0;

  always #10 clk = ~clk;

  i2c_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .scl_in(scl), .sda_in(sda_bus), .sda_pull(sda_pull), .freeze(freeze)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QC) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; q(); scl = 1'b1; q(); s = sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~ack, s);
  endtask

  function automatic bit rsv(input int p);
    return p >= 16 && p <= 18;
  endfunction

  task automatic wr_seq(input logic [7:0] wa, input int n, input int base);
    logic a;
    int p;
    start_c();
    wbyte(8'hD0, a); chk("R1 write device ack", a, 1);
    wbyte(wa, a);    chk("R2 word address ack", a, 1);
    p = (wa < NR) ? int'(wa) : 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = 8'(base + k * 13);
      wbyte(v, a); chk("R2 data ack", a, 1);
      if (!rsv(p)) model[p] = v;
      p = (p + 1) % NR;
    end
    stop_c();
    mptr = p;
  endtask

  task automatic rd_body(input int n, input string tag);
    logic [7:0] d;
    int p;
    p = mptr;
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, d);
      chk(tag, d, model[p]);
      if (k < n - 1) p = (p + 1) % NR;
    end
    chk("R4 sda released after nack", sda_pull, 0);
    stop_c();
    mptr = p;
  endtask

  task automatic rd_rand(input logic [7:0] wa, input int n);
    logic a;
    start_c();
    wbyte(8'hD0, a); chk("R1 device ack", a, 1);
    wbyte(wa, a);    chk("R3 word address ack", a, 1);
    start_c();
    wbyte(8'hD1, a); chk("R3 read device ack", a, 1);
    mptr = int'(wa);
    rd_body(n, "R3 R6 R7 random read data");
  endtask

  task automatic rd_cur(input int n);
    logic a;
    start_c();
    wbyte(8'hD1, a); chk("R5 read device ack", a, 1);
    rd_body(n, "R5 current address data");
  endtask

  initial begin
    logic a, s;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    chk("R10 sda released after reset", sda_pull, 0);
    chk("R10 freeze low after reset", freeze, 0);

    start_c();
    wbyte(8'hA0, a); chk("R1 foreign address nack", a, 0);
    wbyte(8'h00, a); chk("R1 ignored byte nack", a, 0);
    wbyte(8'h55, a); chk("R1 ignored byte nack", a, 0);
    stop_c();
    rd_rand(8'h00, 3);

    wr_seq(8'h00, NR, 5);
    for (int ad = 0; ad < NR; ad++) rd_rand(8'(ad), 3);

    rd_rand(8'h04, 3);
    rd_cur(1);

    wr_seq(8'h13, 2, 8'hA0);
    rd_rand(8'h12, 3);

    wr_seq(8'h40, 1, 8'h33);
    rd_rand(8'h00, 1);
    wr_seq(8'h40, 1, 8'h44);
    rd_cur(1);

    start_c();
    wbyte(8'hD0, a);
    wbyte(8'h06, a);
    chk("R8 freeze with pointer 06h", freeze, 1);
    wbyte(8'h61, a); model[6] = 8'h61;
    chk("R8 freeze with pointer 07h", freeze, 1);
    wbyte(8'h72, a); model[7] = 8'h72;
    chk("R8 freeze drops at pointer 08h", freeze, 0);
    stop_c();
    start_c();
    wbyte(8'hD0, a);
    wbyte(8'h02, a);
    chk("R8 freeze with pointer 02h", freeze, 1);
    stop_c();
    chk("R8 freeze drops on stop", freeze, 0);
    mptr = 2;
    rd_cur(1);

    start_c();
    wbyte(8'hD0, a);
    wbyte(8'h03, a);
    chk("R8 freeze before power fail", freeze, 1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    pwr_fail = 1'b1;
    q();
    chk("R9 freeze low in power fail", freeze, 0);
    chk("R9 sda released in power fail", sda_pull, 0);
    start_c();
    wbyte(8'hD0, a); chk("R9 no ack in power fail", a, 0);
    wbyte(8'h05, a); chk("R9 no ack in power fail", a, 0);
    stop_c();
    pwr_fail = 1'b0;
    q();
    mptr = 0;
    rd_cur(2);
    rd_rand(8'h03, 1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule